// File: doc/BRIEF.md
# Stop-Bit Issue Group Former

This block sits between an instruction fetch stage and a set of execution units. It takes a stream of fixed three-slot bundles. Each slot carries a tag that names the kind of unit it needs and a flag that closes the current issue group. The block then hands out, cycle by cycle, the largest run of slots that may start together. Group boundaries come only from the stop flags. A stop can fall between any two slots, even inside one bundle, and a group can run over as many bundles as it needs. No dependency analysis is done here, because every slot inside one group is treated as independent of the others.

Slots wait in a small ordered holding queue. On every cycle a prefix of that queue is offered on up to `GROUP_W` output lanes, provided the prefix is final. A prefix is final when one of three things ends it: a stop flag, the lane width, or a unit type that has run out of capacity. Slots that do not fit wait for the next cycle in their original order. Each emitted slot carries a running sequence index, so that later stages can put results back in program order.

Top module: `gf_issue_former`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `out_valid` is 0 and `in_ready` is 1.
- R2: Slots leave in the order they arrived, with no reordering within a cycle or across cycles. Within a bundle, slot k sits at `in_unit[2k+1:2k]` and `in_stop[k]`, and slot 0 is the oldest. Output lane l sits at `out_unit[2l+1:2l]` and `out_seq[8l+7:8l]`. Lane 0 is the oldest. Each accepted slot receives a sequence index one higher than the slot before it, starting at 0 after reset and wrapping modulo 256.
- R3: A slot with its stop flag set is the last lane emitted in its cycle, and `out_grp_end` is 1 in that cycle. A slot that follows a stop never shares a cycle with the slots before that stop.
- R4: Slots from several bundles with no stop between them are emitted together in one cycle.
- R5: A stop inside a bundle splits that bundle. The slots after the stop are held and later join slots from following bundles.
- R6: A run of more than `GROUP_W` (default 6) slots without a stop is split into consecutive cycles. Every cycle except the last has `out_grp_end` at 0.
- R7: No cycle emits more slots of one unit code than that code's capacity. The codes are 0 integer, 1 memory, 2 floating point and 3 branch, with default capacities 4, 2, 2 and 1. The first slot that would exceed a capacity, and everything after it, waits for the next cycle with `out_grp_end` at 0.
- R8: Output is offered only when the emitted prefix is final (ended by a stop, by full width or by a capacity limit). Otherwise `out_valid` stays 0 and the held slots wait for more input.
- R9: `in_ready` is 1 exactly when the queue holds at most `GROUP_W` slots.
- R10: `out_lane_vld` is a contiguous run of ones starting at lane 0. `out_valid` equals the OR of its bits. Unused lanes carry zero tags and indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A bundle is offered |
| in_ready | output | 1 | The bundle is taken on this edge if `in_valid` is also 1 |
| in_unit | input | 6 | Unit code of each of the three slots |
| in_stop | input | 3 | Group-closing flag of each slot |
| out_valid | output | 1 | At least one lane carries a slot this cycle |
| out_grp_end | output | 1 | The last valid lane closes its issue group |
| out_lane_vld | output | GROUP_W | Per-lane valid |
| out_unit | output | 2*GROUP_W | Per-lane unit code |
| out_seq | output | SEQ_W*GROUP_W | Per-lane sequence index |

## Verification
The properties assume that every unit capacity is at least one, so the queue head can always leave. They also assume that the slot stream eventually carries a stop, because a trailing run shorter than the lane width with no stop waits for more input by design. Unit tags use only the four codes. The stimulus closes every directed case and the pseudo-random stream with a stop, keeps the default capacities, and holds each bundle steady until it is taken. It mixes back-to-back offers with idle gaps, so the queue fills far enough to drop `in_ready`.

// File: rtl/gf_pkg.sv
package gf_pkg;
   localparam int BUNDLE_SLOTS = 3;
   localparam int UNIT_W       = 2;
   localparam int N_UNITS      = 4;
   localparam int CAP_W        = 4;

   typedef enum logic [UNIT_W-1:0] {
      U_INT = 2'd0,
      U_MEM = 2'd1,
      U_FP  = 2'd2,
      U_BR  = 2'd3
   } unit_e;

   function automatic logic [CAP_W-1:0] cap_of(
      input logic [N_UNITS*CAP_W-1:0] caps,
      input logic [UNIT_W-1:0]        unit
   );
      return caps[unit*CAP_W +: CAP_W];
   endfunction
endpackage

// File: rtl/gf_slot_queue.sv
module gf_slot_queue
   import gf_pkg::*;
#(
   parameter int DEPTH  = 9,
   parameter int SEQ_W  = 8,
   parameter int CNT_W  = 4,
   parameter int PICK_W = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push_en,
   input  logic [BUNDLE_SLOTS*UNIT_W-1:0] push_unit,
   input  logic [BUNDLE_SLOTS-1:0]        push_stop,
   input  logic [PICK_W-1:0]              pop_n,
   output logic [UNIT_W-1:0]              q_unit [DEPTH],
   output logic [DEPTH-1:0]               q_stop,
   output logic [SEQ_W-1:0]               q_seq  [DEPTH],
   output logic [CNT_W-1:0]               count
);

   logic [UNIT_W-1:0] n_unit [DEPTH];
   logic [DEPTH-1:0]  n_stop;
   logic [SEQ_W-1:0]  n_seq  [DEPTH];
   logic [CNT_W-1:0]  n_count;
   logic [SEQ_W-1:0]  seq_ctr;

   always_comb begin
      int keep;
      int src;
      int j;
      keep = int'(count) - int'(pop_n);
      for (int i = 0; i < DEPTH; i++) begin
         n_unit[i] = '0;
         n_stop[i] = 1'b0;
         n_seq[i]  = '0;
         src       = i + int'(pop_n);
         j         = i - keep;
         if (i < keep) begin
            if (src < DEPTH) begin
               n_unit[i] = q_unit[src];
               n_stop[i] = q_stop[src];
               n_seq[i]  = q_seq[src];
            end
         end else if (push_en && (j < BUNDLE_SLOTS)) begin
            n_unit[i] = push_unit[j*UNIT_W +: UNIT_W];
            n_stop[i] = push_stop[j];
            n_seq[i]  = seq_ctr + SEQ_W'(j);
         end
      end
      n_count = CNT_W'(keep + (push_en ? BUNDLE_SLOTS : 0));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count   <= '0;
         seq_ctr <= '0;
         q_stop  <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            q_unit[i] <= '0;
            q_seq[i]  <= '0;
         end
      end else begin
         count  <= n_count;
         q_stop <= n_stop;
         for (int i = 0; i < DEPTH; i++) begin
            q_unit[i] <= n_unit[i];
            q_seq[i]  <= n_seq[i];
         end
         if (push_en) seq_ctr <= seq_ctr + SEQ_W'(BUNDLE_SLOTS);
      end
   end

endmodule

// File: rtl/gf_group_pick.sv
module gf_group_pick
   import gf_pkg::*;
#(
   parameter int                       GROUP_W  = 6,
   parameter int                       DEPTH    = 9,
   parameter int                       CNT_W    = 4,
   parameter int                       PICK_W   = 3,
   parameter logic [N_UNITS*CAP_W-1:0] UNIT_CAP = {4'd1, 4'd2, 4'd2, 4'd4}
) (
   input  logic [UNIT_W-1:0] q_unit [DEPTH],
   input  logic [DEPTH-1:0]  q_stop,
   input  logic [CNT_W-1:0]  count,
   output logic [PICK_W-1:0] take_n,
   output logic [GROUP_W-1:0] lane_vld,
   output logic              grp_end
);

   logic [CAP_W-1:0]  used [N_UNITS];
   logic [PICK_W-1:0] n_sel;
   logic              ended;
   logic              blocked;
   logic              done;
   logic              final_sel;

   always_comb begin
      for (int u = 0; u < N_UNITS; u++) used[u] = '0;
      n_sel   = '0;
      ended   = 1'b0;
      blocked = 1'b0;
      done    = 1'b0;
      for (int i = 0; i < GROUP_W; i++) begin
         if (!done) begin
            if (i >= int'(count)) begin
               done = 1'b1;
            end else if (used[q_unit[i]] >= cap_of(UNIT_CAP, q_unit[i])) begin
               blocked = 1'b1;
               done    = 1'b1;
            end else begin
               used[q_unit[i]] = used[q_unit[i]] + CAP_W'(1);
               n_sel = n_sel + PICK_W'(1);
               if (q_stop[i]) begin
                  ended = 1'b1;
                  done  = 1'b1;
               end
            end
         end
      end
      final_sel = ended || blocked || (int'(n_sel) == GROUP_W);
   end

   assign take_n  = final_sel ? n_sel : '0;
   assign grp_end = final_sel && ended;

   for (genvar l = 0; l < GROUP_W; l++) begin : g_lane_vld
      assign lane_vld[l] = final_sel && (l < int'(n_sel));
   end

endmodule

// File: rtl/gf_issue_former.sv
module gf_issue_former
   import gf_pkg::*;
#(
   parameter int                       GROUP_W  = 6,
   parameter int                       SEQ_W    = 8,
   parameter logic [N_UNITS*CAP_W-1:0] UNIT_CAP = {4'd1, 4'd2, 4'd2, 4'd4}
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   output logic                           in_ready,
   input  logic [BUNDLE_SLOTS*UNIT_W-1:0] in_unit,
   input  logic [BUNDLE_SLOTS-1:0]        in_stop,
   output logic                           out_valid,
   output logic                           out_grp_end,
   output logic [GROUP_W-1:0]             out_lane_vld,
   output logic [GROUP_W*UNIT_W-1:0]      out_unit,
   output logic [GROUP_W*SEQ_W-1:0]       out_seq
);

   localparam int QDEPTH = GROUP_W + BUNDLE_SLOTS;
   localparam int CNT_W  = $clog2(QDEPTH + 1);
   localparam int PICK_W = $clog2(GROUP_W + 1);

   if (GROUP_W < 1) begin : g_bad_width
      $error("GROUP_W must be at least 1");
   end
   if (SEQ_W < 2) begin : g_bad_seq
      $error("SEQ_W must be at least 2");
   end
   for (genvar u = 0; u < N_UNITS; u++) begin : g_cap_chk
      if (UNIT_CAP[u*CAP_W +: CAP_W] == 0) begin : g_zero
         $error("every unit capacity must be nonzero");
      end
   end

   logic [UNIT_W-1:0] q_unit [QDEPTH];
   logic [QDEPTH-1:0] q_stop;
   logic [SEQ_W-1:0]  q_seq  [QDEPTH];
   logic [CNT_W-1:0]  count;
   logic [PICK_W-1:0] take_n;
   logic [GROUP_W-1:0] lane_vld;
   logic              grp_end;
   logic              push_en;

   assign in_ready = (int'(count) <= GROUP_W);
   assign push_en  = in_valid && in_ready;

   gf_slot_queue #(
      .DEPTH (QDEPTH),
      .SEQ_W (SEQ_W),
      .CNT_W (CNT_W),
      .PICK_W(PICK_W)
   ) u_queue (
      .clk      (clk),
      .rst_n    (rst_n),
      .push_en  (push_en),
      .push_unit(in_unit),
      .push_stop(in_stop),
      .pop_n    (take_n),
      .q_unit   (q_unit),
      .q_stop   (q_stop),
      .q_seq    (q_seq),
      .count    (count)
   );

   gf_group_pick #(
      .GROUP_W (GROUP_W),
      .DEPTH   (QDEPTH),
      .CNT_W   (CNT_W),
      .PICK_W  (PICK_W),
      .UNIT_CAP(UNIT_CAP)
   ) u_pick (
      .q_unit  (q_unit),
      .q_stop  (q_stop),
      .count   (count),
      .take_n  (take_n),
      .lane_vld(lane_vld),
      .grp_end (grp_end)
   );

   for (genvar l = 0; l < GROUP_W; l++) begin : g_lane
      assign out_unit[l*UNIT_W +: UNIT_W] = lane_vld[l] ? q_unit[l] : '0;
      assign out_seq[l*SEQ_W +: SEQ_W]    = lane_vld[l] ? q_seq[l]  : '0;
   end

   assign out_lane_vld = lane_vld;
   assign out_valid    = |lane_vld;
   assign out_grp_end  = grp_end;

endmodule

// File: rtl/gf_issue_former_chk.sv
module gf_issue_former_chk
   import gf_pkg::*;
#(
   parameter int                       GROUP_W  = 6,
   parameter int                       SEQ_W    = 8,
   parameter logic [N_UNITS*CAP_W-1:0] UNIT_CAP = {4'd1, 4'd2, 4'd2, 4'd4}
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_ready,
   input logic                      out_valid,
   input logic                      out_grp_end,
   input logic [GROUP_W-1:0]        out_lane_vld,
   input logic [GROUP_W*UNIT_W-1:0] out_unit,
   input logic [GROUP_W*SEQ_W-1:0]  out_seq
);

   int   use_cnt [N_UNITS];
   logic [N_UNITS-1:0] at_cap;

   always_comb begin
      for (int u = 0; u < N_UNITS; u++) use_cnt[u] = 0;
      for (int l = 0; l < GROUP_W; l++) begin
         if (out_lane_vld[l]) begin
            use_cnt[out_unit[l*UNIT_W +: UNIT_W]] = use_cnt[out_unit[l*UNIT_W +: UNIT_W]] + 1;
         end
      end
   end

   p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && in_ready));

   p_ready_needs_output_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |-> out_valid);

   p_lane_prefix_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((out_lane_vld & (out_lane_vld + GROUP_W'(1))) == '0) && (out_valid == (|out_lane_vld)));

   p_end_has_output_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_grp_end |-> out_valid);

   for (genvar u = 0; u < N_UNITS; u++) begin : g_cap
      assign at_cap[u] = (use_cnt[u] == int'(UNIT_CAP[u*CAP_W +: CAP_W]));
      p_unit_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
         use_cnt[u] <= int'(UNIT_CAP[u*CAP_W +: CAP_W]));
   end

   p_short_cut_means_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_grp_end && !out_lane_vld[GROUP_W-1]) |-> (|at_cap));

   for (genvar l = 1; l < GROUP_W; l++) begin : g_seq
      logic [SEQ_W-1:0] prev_plus;
      assign prev_plus = out_seq[(l-1)*SEQ_W +: SEQ_W] + SEQ_W'(1);
      p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
         out_lane_vld[l] |-> (out_seq[l*SEQ_W +: SEQ_W] == prev_plus));
   end

endmodule

bind gf_issue_former gf_issue_former_chk #(
   .GROUP_W (GROUP_W),
   .SEQ_W   (SEQ_W),
   .UNIT_CAP(UNIT_CAP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_grp_end (out_grp_end),
   .out_lane_vld(out_lane_vld),
   .out_unit    (out_unit),
   .out_seq     (out_seq)
);

// File: tb/gf_issue_former_test.sv
module gf_issue_former_test;
   localparam int GW  = 6;
   localparam int SW  = 8;
   localparam int CAP [4] = '{4, 2, 2, 1};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [5:0]    in_unit = '0;
   logic [2:0]    in_stop = '0;
   logic          out_valid;
   logic          out_grp_end;
   logic [GW-1:0] out_lane_vld;
   logic [GW*2-1:0]  out_unit;
   logic [GW*SW-1:0] out_seq;

   int  checks = 0;
   int  errors = 0;
   bit  run = 1'b0;
   bit  log_en = 1'b0;
   int  m_u [$];
   bit  m_s [$];
   int  m_q [$];
   int  mseq = 0;
   int  log_n [$];
   bit  log_e [$];
   logic [15:0] lfsr = 16'hACE1;

   always #10 clk = ~clk;

   gf_issue_former uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_unit(in_unit), .in_stop(in_stop), .out_valid(out_valid),
      .out_grp_end(out_grp_end), .out_lane_vld(out_lane_vld),
      .out_unit(out_unit), .out_seq(out_seq)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic void model_pick(output int n, output bit ended, output bit fin);
      int  used [4];
      bit  done;
      bit  blocked;
      used = '{0, 0, 0, 0};
      n = 0; ended = 0; done = 0; blocked = 0;
      for (int i = 0; i < GW; i++) begin
         if (!done) begin
            if (i >= m_u.size()) done = 1;
            else if (used[m_u[i]] >= CAP[m_u[i]]) begin blocked = 1; done = 1; end
            else begin
               used[m_u[i]]++;
               n++;
               if (m_s[i]) begin ended = 1; done = 1; end
            end
         end
      end
      fin = ended || blocked || (n == GW);
   endfunction

   // monitor: scoreboard pops and compares
   always @(negedge clk) begin
      if (run) begin
         int  n;
         bit  e;
         bit  f;
         int  dn;
         model_pick(n, e, f);
         chk(in_ready == (m_u.size() <= GW), "R9", "in_ready", in_ready, m_u.size() <= GW);
         dn = $countones(out_lane_vld);
         if (!f) begin
            chk(out_valid == 1'b0, "R8", "out_valid while not final", out_valid, 0);
         end else begin
            chk(out_valid == 1'b1, "R8", "out_valid", out_valid, 1);
            chk(out_lane_vld == GW'((1 << n) - 1), "R10", "lane_vld", out_lane_vld, (1 << n) - 1);
            chk(out_grp_end == e, "R3", "grp_end", out_grp_end, e);
            for (int l = 0; l < GW; l++) begin
               if (l < n) begin
                  chk(out_unit[l*2 +: 2] == m_u[l], "R2", "lane unit", out_unit[l*2 +: 2], m_u[l]);
                  chk(out_seq[l*SW +: SW] == m_q[l], "R2", "lane seq", out_seq[l*SW +: SW], m_q[l]);
               end else begin
                  chk(out_unit[l*2 +: 2] == 0 && out_seq[l*SW +: SW] == 0, "R10", "idle lane",
                      out_seq[l*SW +: SW], 0);
               end
            end
            if (log_en) begin log_n.push_back(dn); log_e.push_back(out_grp_end); end
            for (int k = 0; k < n; k++) begin
               void'(m_u.pop_front()); void'(m_s.pop_front()); void'(m_q.pop_front());
            end
         end
      end
   end

   task automatic send(input int u0, input int u1, input int u2, input bit s0, input bit s1, input bit s2);
      bit r;
      forever begin
         @(negedge clk);
         in_valid = 1'b1;
         in_unit  = {u2[1:0], u1[1:0], u0[1:0]};
         in_stop  = {s2, s1, s0};
         r = in_ready;
         @(posedge clk);
         if (r) break;
      end
      m_u.push_back(u0); m_s.push_back(s0); m_q.push_back(mseq); mseq = (mseq + 1) % 256;
      m_u.push_back(u1); m_s.push_back(s1); m_q.push_back(mseq); mseq = (mseq + 1) % 256;
      m_u.push_back(u2); m_s.push_back(s2); m_q.push_back(mseq); mseq = (mseq + 1) % 256;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_chunk(input string req, input int n, input bit e);
      int waited = 0;
      while (log_n.size() == 0 && waited < 40) begin
         @(negedge clk);
         waited++;
      end
      if (log_n.size() == 0) begin
         chk(1'b0, req, "missing group", 0, n);
      end else begin
         int gn;
         bit ge;
         gn = log_n.pop_front();
         ge = log_e.pop_front();
         chk(gn == n, req, "group size", gn, n);
         chk(ge == e, req, "group end", ge, e);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      chk(in_ready == 1'b1, "R1", "in_ready in reset", in_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
      run = 1'b1;
      log_en = 1'b1;

      // R3: stop at the last slot closes a three-slot group
      send(0, 0, 1, 0, 0, 1); idle();
      expect_chunk("R3", 3, 1);

      // R5: stop after slot 0 splits the bundle, the rest is held
      send(0, 2, 0, 1, 0, 0); idle();
      expect_chunk("R5", 1, 1);
      repeat (4) @(negedge clk);
      chk(log_n.size() == 0, "R5", "held slots emitted early", log_n.size(), 0);
      send(0, 0, 0, 1, 0, 0); idle();
      expect_chunk("R5", 3, 1);
      // R4: held pair plus a full bundle form one five-slot group
      send(0, 1, 3, 0, 0, 1); idle();
      expect_chunk("R4", 5, 1);

      // R6: nine slots without stop until the end: split at width six
      send(0, 1, 2, 0, 0, 0);
      send(0, 1, 2, 0, 0, 0);
      send(0, 2, 3, 0, 0, 1); idle();
      expect_chunk("R6", 6, 0);
      expect_chunk("R6", 3, 1);

      // R7: three memory slots against a capacity of two
      send(1, 1, 1, 0, 0, 1); idle();
      expect_chunk("R7", 2, 0);
      expect_chunk("R7", 1, 1);
      // R7: two branch slots against a capacity of one
      send(3, 3, 0, 0, 0, 1); idle();
      expect_chunk("R7", 1, 0);
      expect_chunk("R7", 2, 1);
      log_en = 1'b0;

      // pseudo-random stream, sequence index wraps (R2), in_ready drops (R9)
      for (int b = 0; b < 120; b++) begin
         int u [3];
         bit s [3];
         for (int k = 0; k < 3; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            u[k] = int'(lfsr[1:0]);
            s[k] = (lfsr[4:3] == 2'b00);
         end
         if (b == 119) s[2] = 1'b1;
         send(u[0], u[1], u[2], s[0], s[1], s[2]);
         if (lfsr[7:6] == 2'b00) idle();
      end
      idle();
      repeat (30) @(negedge clk);
      chk(m_u.size() == 0, "R2", "slots left unissued", m_u.size(), 0);
      chk(out_valid == 1'b0, "R8", "output after drain", out_valid, 0);
      chk(mseq == (27 + 360) % 256, "R2", "accepted slot count", mseq, (27 + 360) % 256);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule